// File: doc/BRIEF.md
# Dual Page Buffer

This block holds two independent page buffers for a serial flash front end. Each buffer is a circular byte store whose length is 264 or 256 bytes, chosen by a page-size mode input. A host session begins with a start pulse that latches the buffer select, the starting byte offset and the page-size mode. After that, serial bits, most significant first, are assembled into bytes and stored at an auto-incrementing pointer. Alternatively, a byte-read strobe steps the same pointer so that the buffer can be read out in sequence. Both paths wrap to offset 0 past the last byte of the selected buffer.

A second, independent port serves a program engine. A start pulse on that port streams a whole buffer from offset 0 to its last byte, one byte per cycle, and flags the final byte. Neither host reads nor engine streaming alter the stored bytes. A rising chip select ends the host session and drops any incomplete byte.

Top module: `dual_page_buffer`

## Requirements
- R1: `buf_sel` picks the buffer a session uses (0 = first, 1 = second); the two buffers hold separate contents.
- R2: With `page264` = 1 the 9-bit `start_off` selects the first byte; a value of 264 or more is reduced by 264 before use.
- R3: With `page264` = 0 only `start_off[7:0]` is used; bit 8 is ignored.
- R4: While `cs_n` is low, each `sbit_vld` cycle shifts in `sbit`, first bit is bit 7; the eighth bit stores the byte at the pointer and advances the pointer by one.
- R5: The pointer wraps from the last offset of the session's buffer length (263 or 256-1 = 255) to 0 on writes.
- R6: While `cs_n` is high serial bits are ignored, the pointer holds, and any incomplete byte is discarded, so the next byte after `cs_n` falls again starts fresh at the following offset.
- R7: `rd_data` shows the byte at the pointer of the session's buffer; a `rd_adv` cycle with `cs_n` low advances the pointer, wrapping to 0 after the last offset.
- R8: An `eng_start` pulse while idle raises `eng_valid` from the next cycle for exactly 264 or 256 cycles (by `page264` at the pulse), presenting bytes of `eng_buf` from offset 0 upward on `eng_data`; `eng_last` is high only with the final byte.
- R9: Host reads and engine streaming leave the contents of both buffers unchanged.
- R10: After reset `eng_valid` is low and the host pointer addresses offset 0 of the first buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page264 | input | 1 | Page-size mode: 1 = 264 bytes, 0 = 256 bytes |
| cs_n | input | 1 | Active-low session select |
| sess_start | input | 1 | Latch buffer select, offset and mode; start a session |
| buf_sel | input | 1 | Buffer chosen at session start |
| start_off | input | 9 | Starting byte offset |
| sbit | input | 1 | Serial write bit |
| sbit_vld | input | 1 | Serial bit strobe |
| rd_adv | input | 1 | Byte-read strobe: advance the pointer |
| rd_data | output | 8 | Byte at the host pointer |
| eng_start | input | 1 | Start a whole-buffer stream to the program engine |
| eng_buf | input | 1 | Buffer streamed to the engine |
| eng_valid | output | 1 | Engine byte valid |
| eng_data | output | 8 | Engine byte |
| eng_last | output | 1 | Final byte of the engine stream |

## Verification
A wrong pointer or a wrong length latch shows on `rd_data` on the very next read after the faulty step, and on a wrap the byte read back comes from the wrong end of the buffer. A stale bit count after `cs_n` rises misaligns every later byte, which a read-back of the following offset exposes at once. An engine counter fault shows as a wrong byte, a missing or early `eng_last`, or `eng_valid` staying high for one cycle too many or too few.

// File: rtl/dual_page_buffer.sv
module dual_page_buffer #(
  parameter int LONG_LEN  = 264,
  parameter int SHORT_LEN = 256,
  parameter int AW        = 9,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          page264,
  input  logic          cs_n,
  input  logic          sess_start,
  input  logic          buf_sel,
  input  logic [AW-1:0] start_off,
  input  logic          sbit,
  input  logic          sbit_vld,
  input  logic          rd_adv,
  output logic [DW-1:0] rd_data,
  input  logic          eng_start,
  input  logic          eng_buf,
  output logic          eng_valid,
  output logic [DW-1:0] eng_data,
  output logic          eng_last
);
  localparam int MW = $clog2(2 * LONG_LEN);
  localparam int BW = $clog2(DW);

  logic [DW-1:0] mem [0:2*LONG_LEN-1];

  logic [AW-1:0] ptr, slen, eptr, elen;
  logic          bsel, ebuf, ev;
  logic [BW-1:0] bcnt;
  logic [DW-2:0] shreg;

  function automatic logic [AW-1:0] reduce(input logic [AW-1:0] off, input logic mode);
    if (mode) return (off >= AW'(LONG_LEN)) ? off - AW'(LONG_LEN) : off;
    return off % AW'(SHORT_LEN);
  endfunction

  logic [AW-1:0] ptr_nxt;
  logic          byte_done;
  logic [MW-1:0] hidx, eidx;

  assign ptr_nxt   = (ptr == slen - AW'(1)) ? '0 : ptr + AW'(1);
  assign byte_done = !cs_n && sbit_vld && (bcnt == BW'(DW - 1));
  assign hidx      = MW'(ptr) + (bsel ? MW'(LONG_LEN) : MW'(0));
  assign eidx      = MW'(eptr) + (ebuf ? MW'(LONG_LEN) : MW'(0));
  assign rd_data   = mem[hidx];
  assign eng_data  = mem[eidx];
  assign eng_valid = ev;
  assign eng_last  = ev && (eptr == elen - AW'(1));

  always_ff @(posedge clk)
    if (byte_done && !sess_start) mem[hidx] <= {shreg, sbit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      bsel  <= 1'b0;
      slen  <= AW'(SHORT_LEN);
      bcnt  <= '0;
      shreg <= '0;
    end else if (sess_start) begin
      ptr   <= reduce(start_off, page264);
      bsel  <= buf_sel;
      slen  <= page264 ? AW'(LONG_LEN) : AW'(SHORT_LEN);
      bcnt  <= '0;
    end else if (cs_n) begin
      bcnt  <= '0;
    end else if (sbit_vld) begin
      shreg <= {shreg[DW-3:0], sbit};
      bcnt  <= byte_done ? '0 : bcnt + BW'(1);
      if (byte_done) ptr <= ptr_nxt;
    end else if (rd_adv) begin
      ptr   <= ptr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev   <= 1'b0;
      eptr <= '0;
      ebuf <= 1'b0;
      elen <= AW'(SHORT_LEN);
    end else if (!ev) begin
      if (eng_start) begin
        ev   <= 1'b1;
        eptr <= '0;
        ebuf <= eng_buf;
        elen <= page264 ? AW'(LONG_LEN) : AW'(SHORT_LEN);
      end
    end else if (eng_last) begin
      ev <= 1'b0;
    end else begin
      eptr <= eptr + AW'(1);
    end
  end
endmodule

// File: rtl/dual_page_buffer_chk.sv
module dual_page_buffer_chk #(
  parameter int AW = 9,
  parameter int BW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sess_start,
  input logic          sbit_vld,
  input logic          rd_adv,
  input logic [AW-1:0] ptr,
  input logic [AW-1:0] slen,
  input logic [BW-1:0] bcnt,
  input logic [AW-1:0] eptr,
  input logic          eng_valid,
  input logic          eng_last
);
  assert_ptr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < slen);

  assert_partial_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> bcnt == '0);

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !sess_start) |=> ptr == $past(ptr));

  assert_read_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !sess_start && !sbit_vld && rd_adv && ptr == slen - AW'(1)) |=> ptr == '0);

  assert_eng_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_last) |=> (eng_valid && eptr == $past(eptr) + AW'(1)));

  assert_eng_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && eng_last) |=> !eng_valid);
endmodule

bind dual_page_buffer dual_page_buffer_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sess_start(sess_start),
  .sbit_vld(sbit_vld), .rd_adv(rd_adv), .ptr(ptr), .slen(slen), .bcnt(bcnt),
  .eptr(eptr), .eng_valid(eng_valid), .eng_last(eng_last)
);

// File: tb/sim_dual_page_buffer.sv
`timescale 1ns/1ps
module sim_dual_page_buffer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic page264 = 1'b1, cs_n = 1'b1, sess_start = 1'b0, buf_sel = 1'b0;
  logic [8:0] start_off = '0;
  logic sbit = 1'b0, sbit_vld = 1'b0, rd_adv = 1'b0;
  logic eng_start = 1'b0, eng_buf = 1'b0;
  logic [7:0] rd_data, eng_data;
  logic eng_valid, eng_last;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] model [0:527];

  always #10 clk = ~clk;

  dual_page_buffer u0 (
    .clk(clk), .rst_n(rst_n), .page264(page264), .cs_n(cs_n), .sess_start(sess_start),
    .buf_sel(buf_sel), .start_off(start_off), .sbit(sbit), .sbit_vld(sbit_vld),
    .rd_adv(rd_adv), .rd_data(rd_data), .eng_start(eng_start), .eng_buf(eng_buf),
    .eng_valid(eng_valid), .eng_data(eng_data), .eng_last(eng_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  function automatic int eff_off(input int off, input bit mode);
    if (mode) return (off >= 264) ? off - 264 : off;
    return off % 256;
  endfunction

  task automatic start_sess(input bit b, input int off, input bit mode);
    page264 = mode; buf_sel = b; start_off = 9'(off); cs_n = 1'b0; sess_start = 1'b1;
    tick;
    sess_start = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sbit = v[i]; sbit_vld = 1'b1; tick;
    end
    sbit_vld = 1'b0;
  endtask

  task automatic write_run(input bit b, input int off, input bit mode, input int n, input int seed);
    int a = eff_off(off, mode);
    int len = mode ? 264 : 256;
    start_sess(b, off, mode);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v = 8'((seed + k * 37) & 255);
      send_bits(v, 8);
      model[b * 264 + a] = v;
      a = (a + 1) % len;
    end
    cs_n = 1'b1; tick;
  endtask

  task automatic read_run(input bit b, input int off, input bit mode, input int n, input string tag);
    int a = eff_off(off, mode);
    int len = mode ? 264 : 256;
    start_sess(b, off, mode);
    for (int k = 0; k < n; k++) begin
      chk(rd_data === model[b * 264 + a], tag, rd_data, model[b * 264 + a]);
      rd_adv = 1'b1; tick; rd_adv = 1'b0;
      a = (a + 1) % len;
    end
    cs_n = 1'b1; tick;
  endtask

  task automatic t_reset;
    chk(eng_valid === 1'b0, "R10 eng_valid after reset", eng_valid, 0);
    cs_n = 1'b0;
    send_bits(8'hC3, 8);
    model[0] = 8'hC3;
    cs_n = 1'b1; tick;
    read_run(1'b0, 0, 1'b1, 1, "R10 pointer at offset 0 of first buffer");
  endtask

  task automatic t_fill;
    write_run(1'b0, 0, 1'b1, 264, 11);
    write_run(1'b1, 0, 1'b1, 264, 200);
    read_run(1'b0, 0, 1'b1, 264, "R4 full read of first buffer");
    read_run(1'b1, 0, 1'b1, 264, "R4 full read of second buffer");
  endtask

  task automatic t_two_buffers;
    write_run(1'b0, 10, 1'b1, 1, 8'hA5);
    write_run(1'b1, 10, 1'b1, 1, 8'h5A);
    read_run(1'b0, 10, 1'b1, 1, "R1 first buffer keeps its byte");
    read_run(1'b1, 10, 1'b1, 1, "R1 second buffer keeps its byte");
  endtask

  task automatic t_wrap264;
    write_run(1'b1, 262, 1'b1, 4, 8'h40);
    read_run(1'b1, 262, 1'b1, 4, "R5 write wrap at 263 and R7 read wrap");
    read_run(1'b1, 0, 1'b1, 2, "R5 wrapped bytes at offsets 0 and 1");
  endtask

  task automatic t_offset_mod;
    write_run(1'b0, 300, 1'b1, 1, 8'h9C);
    chk(model[36] === 8'h9C, "R2 model offset 300 maps to 36", model[36], 8'h9C);
    read_run(1'b0, 36, 1'b1, 1, "R2 offset 300 reduced to 36");
    read_run(1'b0, 300, 1'b1, 2, "R2 read at offset 300");
  endtask

  task automatic t_mode256;
    write_run(1'b0, 9'h1FE, 1'b0, 3, 8'h77);
    read_run(1'b0, 254, 1'b0, 3, "R3 bit 8 ignored and R5 wrap at 255");
    read_run(1'b0, 255, 1'b0, 2, "R7 read wrap at 255 in short mode");
    read_run(1'b0, 256, 1'b1, 1, "R3 offset 256 left untouched");
  endtask

  task automatic t_partial;
    start_sess(1'b1, 50, 1'b1);
    send_bits(8'h11, 8); model[264 + 50] = 8'h11;
    send_bits(8'hFF, 3);
    cs_n = 1'b1;
    send_bits(8'hEE, 8);
    rd_adv = 1'b1; tick; rd_adv = 1'b0;
    cs_n = 1'b0;
    send_bits(8'h22, 8); model[264 + 51] = 8'h22;
    cs_n = 1'b1; tick;
    read_run(1'b1, 50, 1'b1, 3, "R6 partial byte dropped, bits ignored while deselected");
  endtask

  task automatic t_engine(input bit b, input bit mode, input string tag);
    int len = mode ? 264 : 256;
    page264 = mode; eng_buf = b; eng_start = 1'b1; tick; eng_start = 1'b0;
    for (int k = 0; k < len; k++) begin
      chk(eng_valid === 1'b1, tag, eng_valid, 1);
      chk(eng_data === model[b * 264 + k], tag, eng_data, model[b * 264 + k]);
      chk(eng_last === (k == len - 1), {tag, " last flag"}, eng_last, k == len - 1);
      tick;
    end
    chk(eng_valid === 1'b0, {tag, " stream ended"}, eng_valid, 0);
  endtask

  task automatic t_unchanged;
    read_run(1'b0, 0, 1'b1, 264, "R9 first buffer unchanged");
    read_run(1'b1, 0, 1'b1, 264, "R9 second buffer unchanged");
  endtask

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    t_reset;
    t_fill;
    t_two_buffers;
    t_wrap264;
    t_offset_mod;
    t_mode256;
    t_partial;
    t_engine(1'b1, 1'b1, "R8 long stream of second buffer");
    t_engine(1'b0, 1'b0, "R8 short stream of first buffer");
    t_unchanged;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule